// File: doc/BRIEF.md
# Two-Phase Triggered Pulse Sequencer

This block is a two-state synchronous controller driven by one active-low trigger. While idle it watches the trigger. Once the trigger is sampled LOW, it emits a single-clock pulse on output A. On the clock after that, it emits a single-clock pulse on output B. It then returns to idle. If the trigger is still LOW at that point, the A/B pair starts again at once, so a held trigger gives a steady alternating train with a period of two clocks.

A parameter chooses how the outputs are formed. In the combinational form, output A is decoded from the idle state together with the live trigger level. A reacts within the same cycle, and an input change between clock edges can glitch it. In the registered form, both outputs come from flip-flops. They never change between edges, and they trail the combinational waveforms by exactly one clock.

Synchronising or debouncing the trigger is left to the logic that drives it.

Top module: `pulse_pair_seq`

## Requirements
- R1: A synchronous active-high reset puts the sequencer in its idle state, encoded 0. After a clock edge with reset high, both outputs are LOW. In the combinational form the outputs are also held LOW while reset is high.
- R2: In the idle state with the trigger HIGH, the sequencer stays idle and both outputs stay LOW.
- R3: A trigger sampled LOW in the idle state moves the sequencer to its armed state, encoded 1, and produces a pulse on output A exactly one clock wide.
- R4: Output B pulses for exactly one clock, in the cycle right after the A pulse, whatever the trigger does in that cycle. The sequencer then returns to idle.
- R5: Outputs A and B are never HIGH in the same cycle.
- R6: With the trigger held LOW, the A/B pair repeats with no idle gap: A, B, A, B and so on.
- R7: With OUT_MODE=0, output A equals "idle and trigger LOW" combinationally. It can rise and fall between clock edges.
- R8: With OUT_MODE=1, both outputs are registered. Each equals the OUT_MODE=0 waveform delayed by one clock, and neither changes between clock edges.
- R9: OUT_MODE accepts only the values 0 and 1. Any other value stops elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_n | input | 1 | Active-low trigger, already synchronous to clk |
| pulse_a | output | 1 | First pulse of each pair |
| pulse_b | output | 1 | Second pulse, one clock after pulse_a |

## Verification
The bench drives both output forms side by side with the same trigger pattern. The pattern covers an isolated LOW, a LOW held over several cycles, and a trigger that goes HIGH during the armed cycle.

Each failure shows up differently:
- A sequencer that sticks in the armed state, or that only restarts when the trigger rises, breaks the A, B, A, B train.
- One that waits on the trigger in the armed state drops the B pulse.
- A registered form that is missing its delay, or that still decodes the live trigger, changes output A between edges.
- Reset applied in the armed cycle must suppress the pending B pulse. A reset that only blocks new triggers would let it through.

// File: rtl/pulse_pair_pkg.sv
package pulse_pair_pkg;

   typedef enum logic {
      PH_IDLE  = 1'b0,
      PH_ARMED = 1'b1
   } phase_t;

   localparam int OUT_COMB = 0;
   localparam int OUT_REG  = 1;

endpackage

// File: rtl/pulse_pair_state.sv
module pulse_pair_state
   import pulse_pair_pkg::*;
(
   input  logic   clk,
   input  logic   rst,
   input  logic   trig_n,
   output phase_t phase
);

   phase_t phase_nxt;

   always_comb begin
      unique case (phase)
         PH_IDLE:  phase_nxt = trig_n ? PH_IDLE : PH_ARMED;
         PH_ARMED: phase_nxt = PH_IDLE;
         default:  phase_nxt = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) phase <= PH_IDLE;
      else     phase <= phase_nxt;
   end

endmodule

// File: rtl/pulse_pair_decode.sv
module pulse_pair_decode
   import pulse_pair_pkg::*;
(
   input  logic   rst,
   input  logic   trig_n,
   input  phase_t phase,
   output logic   dec_a,
   output logic   dec_b
);

   always_comb begin
      dec_a = !rst && (phase == PH_IDLE) && !trig_n;
      dec_b = !rst && (phase == PH_ARMED);
   end

endmodule

// File: rtl/pulse_pair_oreg.sv
module pulse_pair_oreg #(
   parameter int WIDTH = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= d;
   end

endmodule

// File: rtl/pulse_pair_seq.sv
module pulse_pair_seq
   import pulse_pair_pkg::*;
#(
   parameter int OUT_MODE = OUT_COMB
) (
   input  logic clk,
   input  logic rst,
   input  logic trig_n,
   output logic pulse_a,
   output logic pulse_b
);

   localparam int NUM_OUT = 2;

   phase_t phase;
   logic   dec_a;
   logic   dec_b;

   pulse_pair_state u_state (
      .clk    (clk),
      .rst    (rst),
      .trig_n (trig_n),
      .phase  (phase)
   );

   pulse_pair_decode u_dec (
      .rst    (rst),
      .trig_n (trig_n),
      .phase  (phase),
      .dec_a  (dec_a),
      .dec_b  (dec_b)
   );

   generate
      if (OUT_MODE == OUT_COMB) begin : g_comb
         assign pulse_a = dec_a;
         assign pulse_b = dec_b;
      end else if (OUT_MODE == OUT_REG) begin : g_reg
         logic [NUM_OUT-1:0] q;
         pulse_pair_oreg #(.WIDTH(NUM_OUT)) u_oreg (
            .clk (clk),
            .rst (rst),
            .d   ({dec_b, dec_a}),
            .q   (q)
         );
         assign pulse_a = q[0];
         assign pulse_b = q[1];
      end else begin : g_bad_mode
         $error("pulse_pair_seq: OUT_MODE must be 0 or 1"); // R9
         assign pulse_a = 1'b0;
         assign pulse_b = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/pulse_pair_seq_chk.sv
module pulse_pair_seq_chk #(
   parameter int OUT_MODE = 0
) (
   input logic clk,
   input logic rst,
   input logic trig_n,
   input logic pulse_a,
   input logic pulse_b
);

   AST_A_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst) pulse_a |=> !pulse_a); // R3
   AST_B_FOLLOWS_A: assert property (@(posedge clk) disable iff (rst) pulse_a |=> pulse_b); // R4
   AST_B_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst) pulse_b |=> !pulse_b); // R4
   AST_NO_OVERLAP:  assert property (@(posedge clk) disable iff (rst) !(pulse_a && pulse_b)); // R5
   AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !pulse_b); // R1

   generate
      if (OUT_MODE == 0) begin : g_comb_chk
         AST_A_NEEDS_LOW: assert property (@(posedge clk) disable iff (rst) pulse_a |-> !trig_n); // R7
      end else begin : g_reg_chk
         AST_A_AFTER_LOW: assert property (@(posedge clk) disable iff (rst) pulse_a |-> !$past(trig_n)); // R8
      end
   endgenerate

endmodule

bind pulse_pair_seq pulse_pair_seq_chk #(.OUT_MODE(OUT_MODE)) u_chk (
   .clk     (clk),
   .rst     (rst),
   .trig_n  (trig_n),
   .pulse_a (pulse_a),
   .pulse_b (pulse_b)
);

// File: tb/tb_pulse_pair_seq.sv
module tb_pulse_pair_seq;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 14;
   // each entry: {trig_n, comb_a, comb_b, reg_a, reg_b}
   localparam logic [4:0] VEC [NVEC] = '{
      5'b1_00_00, 5'b1_00_00, 5'b0_10_00, 5'b1_01_10,
      5'b1_00_01, 5'b0_10_00, 5'b0_01_10, 5'b0_10_01,
      5'b0_01_10, 5'b1_00_01, 5'b1_00_00, 5'b0_10_00,
      5'b1_01_10, 5'b1_00_01
   };

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic trig_n = 1'b1;
   logic ca, cb, ra, rb;
   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pulse_pair_seq #(.OUT_MODE(0)) dut (
      .clk(clk), .rst(rst), .trig_n(trig_n), .pulse_a(ca), .pulse_b(cb));

   pulse_pair_seq #(.OUT_MODE(1)) dut_reg (
      .clk(clk), .rst(rst), .trig_n(trig_n), .pulse_a(ra), .pulse_b(rb));

   task automatic chk(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, act, exp);
      end
   endtask

   initial begin
      #(CLK_PERIOD*5000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      // R1: reset held with trigger LOW keeps everything quiet
      trig_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk); #1;
      chk("R1 comb a in reset", ca, 1'b0);
      chk("R1 comb b in reset", cb, 1'b0);
      chk("R1 reg a in reset", ra, 1'b0);
      chk("R1 reg b in reset", rb, 1'b0);
      trig_n = 1'b1;
      rst = 1'b0;

      // vector walk: R2 R3 R4 R5 R6 R7 R8
      for (int i = 0; i < NVEC; i++) begin
         @(negedge clk);
         trig_n = VEC[i][4];
         #2;
         chk($sformatf("R3/R7 comb a vec%0d", i), ca, VEC[i][3]);
         chk($sformatf("R4/R6 comb b vec%0d", i), cb, VEC[i][2]);
         chk($sformatf("R8 reg a vec%0d", i), ra, VEC[i][1]);
         chk($sformatf("R8/R5 reg b vec%0d", i), rb, VEC[i][0]);
      end

      // R7/R8: trigger glitch between edges while idle
      @(negedge clk);
      trig_n = 1'b1; #1;
      chk("R2 comb a idle", ca, 1'b0);
      trig_n = 1'b0; #1;
      chk("R7 comb a follows trig", ca, 1'b1);
      chk("R8 reg a stable mid-cycle", ra, 1'b0);
      trig_n = 1'b1; #1;
      chk("R7 comb a drops with trig", ca, 1'b0);
      chk("R8 reg a still stable", ra, 1'b0);
      @(negedge clk); #1;
      chk("R2 comb a stays idle", ca, 1'b0);
      chk("R2 comb b stays idle", cb, 1'b0);
      chk("R2 reg a no late pulse", ra, 1'b0);
      chk("R2 reg b no late pulse", rb, 1'b0);

      // R1: reset in the armed cycle cancels the B pulse
      trig_n = 1'b0; #1;
      chk("R3 comb a before arm", ca, 1'b1);
      @(negedge clk);
      rst = 1'b1; trig_n = 1'b1; #1;
      chk("R1 comb b gated by reset", cb, 1'b0);
      @(negedge clk);
      rst = 1'b0; #1;
      chk("R1 comb b after reset", cb, 1'b0);
      chk("R1 reg a after reset", ra, 1'b0);
      chk("R1 reg b after reset", rb, 1'b0);
      @(negedge clk); #1;
      chk("R1 comb b idle after reset", cb, 1'b0);
      chk("R1 reg b no leftover pulse", rb, 1'b0);

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule